// File: doc/BRIEF.md
# Recursive Quad-Split Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product in a single combinational path. There is no clock, no handshake and no sign handling. It is meant to sit inside a datapath stage whose registers belong to the surrounding logic. N is a parameter and must be a power of two, 2 or larger.

The product comes from a split into halves at every width. The smallest unit is a 2x2 cell. Its lowest result bit is the AND of the two low operand bits. Its two cross terms go into a half adder to form the middle bit. The carry from that half adder goes into a second half adder together with the AND of the two high bits. A block of width W uses four blocks of width W/2, all working in parallel: low×low, high(a)×low(b), low(a)×high(b) and high×high. Each of their results is zero-padded into a 2W-bit word at its weight (0, W/2, W/2 or W). The four words are then summed in one addition for that level. The levels are built from 2x2 cells upward until they reach the requested width.

Top module: `vcm_mult`

## Requirements
- R1: `prod` equals the unsigned product of `op_a` and `op_b`, exact in 2N bits, for every operand pair.
- R2: `prod[0]` equals `op_a[0] & op_b[0]`.
- R3: When either operand is zero, `prod` is zero, whatever the other operand is.
- R4: When one operand equals 1, `prod` equals the other operand zero-extended to 2N bits.
- R5: All-ones times all-ones gives (2^N-1)^2. The upper N bits are all ones except for bit N, which is 0. The lower N bits are zero except for bit 0, which is 1.
- R6: When both operands are below 2^(N/2), the upper N bits of `prod` are zero.
- R7: When `op_a` has only bit i set and `op_b` has only bit j set, `prod` has exactly one bit set, at position i+j.
- R8: Operands 4'b1111 and 4'b1010, zero-extended, give 8'b10010110 (decimal 150).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product, combinational |

## Verification
Random operands rarely produce a carry that travels through all the upper bits of the top-level addition. All-ones times all-ones is the operand pair that does this. The bench applies that pair on purpose, and it also applies the single-bit-set pairs. These one-hot pairs place one set bit in each of the four sub-product positions in turn, so a wrong shift or a swapped quadrant shows up as a misplaced bit. After that, several thousand random pairs are compared against the built-in multiplication.

// File: rtl/vcm_pkg.sv
// Package: shared helpers for the quad-split multiplier.
// Assumes widths passed in are powers of two, 2 or larger.
package vcm_pkg;

    // Number of recursion levels for an operand width (2 -> 1, 4 -> 2, ...)
    function automatic int vcm_level_count(input int width);
        return $clog2(width);
    endfunction

    // True when a width is a legal operand width for this multiplier
    function automatic bit vcm_width_ok(input int width);
        return (width >= 2) && ((width & (width - 1)) == 0);
    endfunction

endpackage

// File: rtl/vcm_half_add.sv
// Module: one-bit half adder.
// Produces sum (XOR) and carry (AND) of two bits; purely combinational.
module vcm_half_add (
    input  logic x_i,
    input  logic y_i,
    output logic sum_o,
    output logic cry_o
);

    // Sum and carry of two single bits
    always_comb begin
        sum_o = x_i ^ y_i;
        cry_o = x_i & y_i;
    end

endmodule

// File: rtl/vcm_cell2.sv
// Module: 2x2 unsigned multiplier cell, the leaf of the recursion.
// Forms the four bit products with AND gates. The two cross terms and the
// high term are combined through two half adders, so the cell holds
// exactly two XOR gates. Assumes unsigned 2-bit operands.
module vcm_cell2 (
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [3:0] p_o
);

    logic t_lo;
    logic t_x0;
    logic t_x1;
    logic t_hi;
    logic mid_cry;

    // Bit products of the operands
    always_comb begin
        t_lo = a_i[0] & b_i[0];
        t_x0 = a_i[1] & b_i[0];
        t_x1 = a_i[0] & b_i[1];
        t_hi = a_i[1] & b_i[1];
    end

    vcm_half_add u_mid (
        .x_i   (t_x0),
        .y_i   (t_x1),
        .sum_o (p_o[1]),
        .cry_o (mid_cry)
    );

    vcm_half_add u_top (
        .x_i   (t_hi),
        .y_i   (mid_cry),
        .sum_o (p_o[2]),
        .cry_o (p_o[3])
    );

    assign p_o[0] = t_lo;

endmodule

// File: rtl/vcm_merge.sv
// Module: one recursion level's combine step.
// Takes four sub-products of two S-bit halves, zero-pads each into a
// 4S-bit word at its weight (0, S, S, 2S) and adds the four words in a
// single addition. Assumes S >= 1; the sum cannot exceed 4S bits.
module vcm_merge #(
    parameter int S = 1
) (
    input  logic [2*S-1:0] ll_i,
    input  logic [2*S-1:0] hl_i,
    input  logic [2*S-1:0] lh_i,
    input  logic [2*S-1:0] hh_i,
    output logic [4*S-1:0] p_o
);

    localparam int OW = 4 * S;

    logic [OW-1:0] w_ll;
    logic [OW-1:0] w_hl;
    logic [OW-1:0] w_lh;
    logic [OW-1:0] w_hh;

    // Zero-pad each sub-product to full width at its weight
    always_comb begin
        w_ll = {{(2*S){1'b0}}, ll_i};
        w_hl = {{S{1'b0}}, hl_i, {S{1'b0}}};
        w_lh = {{S{1'b0}}, lh_i, {S{1'b0}}};
        w_hh = {hh_i, {(2*S){1'b0}}};
    end

    // Single four-input addition for this level
    always_comb begin
        p_o = w_ll + w_hl + w_lh + w_hh;
    end

endmodule

// File: rtl/vcm_mult.sv
// Module: top of the recursive quad-split unsigned multiplier.
// Level 0 tiles the operands into 2-bit slices and multiplies every
// slice pair in a 2x2 cell. Each later level doubles the block width by
// merging four neighbouring blocks of the level below. The final level
// holds one block: the full 2N-bit product. Assumes N is a power of two,
// 2 or larger; purely combinational.
module vcm_mult
    import vcm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);

    localparam int LV = vcm_level_count(N);

    for (genvar k = 0; k < LV; k++) begin : lv
        localparam int W = 2 << k;     // block operand width at this level
        localparam int M = N / W;      // blocks per operand side
        localparam int H = W / 2;      // half width
        logic [2*W-1:0] part [M*M];

        if (k == 0) begin : g_leaf
            for (genvar i = 0; i < M; i++) begin : g_i
                for (genvar j = 0; j < M; j++) begin : g_j
                    vcm_cell2 u_cell (
                        .a_i (op_a[i*2 +: 2]),
                        .b_i (op_b[j*2 +: 2]),
                        .p_o (part[i*M + j])
                    );
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < M; i++) begin : g_i
                for (genvar j = 0; j < M; j++) begin : g_j
                    vcm_merge #(.S(H)) u_merge (
                        .ll_i (lv[k-1].part[(2*i)   * (2*M) + 2*j]),
                        .hl_i (lv[k-1].part[(2*i+1) * (2*M) + 2*j]),
                        .lh_i (lv[k-1].part[(2*i)   * (2*M) + 2*j + 1]),
                        .hh_i (lv[k-1].part[(2*i+1) * (2*M) + 2*j + 1]),
                        .p_o  (part[i*M + j])
                    );
                end
            end
        end
    end

    assign prod = lv[LV-1].part[0];

endmodule

// File: rtl/vcm_mult_chk.sv
// Module: property checker for vcm_mult, attached by bind.
// Compares the product with the arithmetic meaning of the operands using
// immediate assertions evaluated whenever the operands or product change.
module vcm_mult_chk
    import vcm_pkg::*;
#(
    parameter int N = 16
) (
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [2*N-1:0] prod
);

    localparam int HN = N / 2;

    logic [2*N-1:0] ref_p;
    logic [2*N-1:0] ones_sq;
    logic [N-1:0]   one_n;

    // Elaboration-time width legality
    initial begin
        width_legal_chk: assert (vcm_width_ok(N)) else $error("N must be a power of two >= 2");
    end

    // Reference values for the properties
    always_comb begin
        ref_p   = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};
        ones_sq = {{N{1'b0}}, {N{1'b1}}} * {{N{1'b0}}, {N{1'b1}}};
        one_n   = {{(N-1){1'b0}}, 1'b1};
    end

    // Checks on the combinational result
    always_comb begin
        // R1
        exact_product_chk: assert (prod == ref_p) else $error("R1 product mismatch");
        // R2
        low_bit_chk: assert (prod[0] == (op_a[0] & op_b[0])) else $error("R2 low bit");
        // R3
        zero_operand_chk: assert (!(op_a == '0 || op_b == '0) || prod == '0) else $error("R3 zero operand");
        // R4
        unit_operand_chk: assert (!(op_a == one_n) || prod == {{N{1'b0}}, op_b}) else $error("R4 unit operand");
        // R5
        full_ones_chk: assert (!(&op_a && &op_b) || prod == ones_sq) else $error("R5 all ones");
        // R6
        no_overflow_chk: assert (!(op_a[N-1:HN] == '0 && op_b[N-1:HN] == '0) || prod[2*N-1:N] == '0) else $error("R6 upper half");
        // R7
        onehot_pair_chk: assert (!($countones(op_a) == 1 && $countones(op_b) == 1) || $countones(prod) == 1) else $error("R7 one-hot");
    end

endmodule

bind vcm_mult vcm_mult_chk #(.N(N)) u_vcm_mult_chk (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/test_vcm_mult.sv
// Bench: drives operand pairs on the rising edge and queues the expected
// product (built-in multiply on 64-bit integers); each falling edge pops
// the queue and compares with the design output.
module test_vcm_mult;

    localparam int N = 16;
    localparam int MAXCYC = 200000;

    logic           clk;
    logic           rst_n;
    logic [N-1:0]   op_a;
    logic [N-1:0]   op_b;
    logic [2*N-1:0] prod;

    int checks;
    int errors;
    int cycles;
    bit done;

    longint unsigned exp_q [$];
    string           tag_q [$];

    vcm_mult #(.N(N)) i_vcm_mult (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    // 100 MHz clock
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Compare one value and count it
    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply a pair on the rising edge, compare on the following falling edge
    task automatic apply(input longint unsigned a, input longint unsigned b, input string req);
        longint unsigned e;
        @(posedge clk);
        op_a = a[N-1:0];
        op_b = b[N-1:0];
        e = (a & 64'hFFFF) * (b & 64'hFFFF);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        check(tag_q.pop_front(), {32'd0, prod}, exp_q.pop_front());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > MAXCYC) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAXCYC);
                finish_run();
            end
        end
    end

    // Stimulus
    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        op_a   = '0;
        op_b   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero operands give zero product (R3)
        check("R3 reset", {32'd0, prod}, 64'd0);
        rst_n = 1'b1;

        // R8 worked case
        apply(64'hF, 64'hA, "R8");
        @(negedge clk);
        check("R8 value", {32'd0, prod}, 64'd150);

        // R2 low bit patterns
        apply(64'h0001, 64'h0003, "R2");
        apply(64'h0002, 64'h0003, "R2");
        @(negedge clk);
        check("R2 bit0", {63'd0, prod[0]}, 64'd0);

        // R3 zero operand
        apply(64'h0, 64'hBEEF, "R3");
        apply(64'hFFFF, 64'h0, "R3");

        // R4 unit operand
        apply(64'h1, 64'h9C3A, "R4");
        apply(64'hFFFF, 64'h1, "R4");

        // R5 all ones, explicit expected value
        apply(64'hFFFF, 64'hFFFF, "R5");
        @(negedge clk);
        check("R5 value", {32'd0, prod}, 64'hFFFE0001);

        // R6 both below 2^(N/2)
        apply(64'h00FF, 64'h00FF, "R6");
        @(negedge clk);
        check("R6 upper", {48'd0, prod[2*N-1:N]}, 64'd0);

        // R7 every single-bit pair
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                apply(64'd1 << i, 64'd1 << j, "R7");
                @(negedge clk);
                check("R7 count", longint'($countones(prod)), 64'd1);
            end
        end

        // R1 random pairs
        for (int n = 0; n < 4000; n++) begin
            apply({32'd0, $urandom}, {32'd0, $urandom}, "R1");
        end

        finish_run();
    end

endmodule